// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Sequencer

This block sets the timing of a small processor that uses one-word instructions. It takes a fast input clock and divides it into four non-overlapping phase strobes, called Q1 through Q4. One pass through all four phases makes one instruction cycle. The block holds the program counter and the instruction register. In each instruction cycle, the word at the program counter is fetched while the word fetched in the cycle before is executed. The fetch address goes out on `pm_addr`. The returned word on `pm_data` is captured on the clock edge that closes Q4.

The execute logic uses two strobes from this block. `opr_rd_stb` marks Q2 as the operand-read slot, and `dst_wr_stb` marks Q4 as the destination-write slot. When the execute logic asks for a jump, it raises `redirect_req` together with a target address. It may do this in any phase of the cycle. At the end of that cycle the block loads the target into the program counter. It then throws away the word that was prefetched and puts the no-operation word `NOP_WORD` in its place. This forced no-op is called a bubble. During a bubble cycle `ex_bubble` is high, both memory strobes stay low and jump requests are ignored. A taken jump therefore costs two instruction cycles.

A free-running divided clock, `clk_out`, runs at the instruction-cycle rate. It is high during Q3 and Q4.

Top module: `qphase_seq`

## Requirements
- R1: `q_phase` is one-hot. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. Each input clock edge moves the active bit Q1→Q2→Q3→Q4→Q1.
- R2: A synchronous active-high `rst` gives the following state. `q_phase` is Q1, `pm_addr` is 0, `ir` equals `NOP_WORD` and `ex_bubble` is 1.
- R3: `pm_addr` changes only on the edge that moves the phase from Q4 to Q1. It stays steady through Q1..Q4 of a cycle.
- R4: If no jump is taken, the edge that ends Q4 does three things. It loads `ir` with the current `pm_data`. It advances `pm_addr` by one, modulo 2^ADDR_W. It clears `ex_bubble`.
- R5: `opr_rd_stb` is high exactly during Q2, and `dst_wr_stb` exactly during Q4, of cycles with `ex_bubble` low. Both are low at all other times.
- R6: `clk_out` is high during Q3 and Q4 and low during Q1 and Q2.
- R7: Suppose `redirect_req` is high in any phase of a cycle with `ex_bubble` low. Then the next cycle shows `pm_addr` equal to the target, `ir` equal to `NOP_WORD` and `ex_bubble` high. The cycle after that holds the word fetched from the target in `ir`.
- R8: A `redirect_req` raised during a cycle with `ex_bubble` high has no effect. Fetch continues in sequence at the next address.
- R9: If `redirect_req` is high in more than one phase of a cycle, the target presented in the last such phase is the one loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four edges per instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| q_phase | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| clk_out | output | 1 | Instruction-rate clock, high in Q3/Q4 |
| pm_addr | output | ADDR_W | Program memory fetch address (program counter) |
| pm_data | input | INSTR_W | Instruction word from program memory, combinational read |
| ir | output | INSTR_W | Instruction register, the word in the execute stage |
| ex_bubble | output | 1 | Execute stage holds a forced no-op |
| redirect_req | input | 1 | Jump request from the execute logic |
| redirect_addr | input | ADDR_W | Jump target address |
| opr_rd_stb | output | 1 | Operand read slot (Q2 of a live execute cycle) |
| dst_wr_stb | output | 1 | Destination write slot (Q4 of a live execute cycle) |

## Verification
The bench runs a 4-bit address, 8-bit word build. It checks every output in every phase against a cycle-level model.

- **Wrap-around.** A long sequential run makes the program counter wrap past its top address. A counter that saturated or overflowed would show the wrong fetch address after 15.
- **Jumps in every phase.** Jump pulses are placed in each of the four phases, with targets that cover all sixteen addresses. A design that sampled the request only in Q4 would miss the early pulses and keep fetching in sequence.
- **Jumps in bubble cycles.** Requests are also raised in the bubble cycle right after each jump. A design that honoured them would jump twice, or would never leave the bubble state.
- **Two pulses in one cycle.** Some cycles carry two pulses with different targets. A design that kept the first target would branch to the wrong address.
- **Reset in mid-cycle.** A reset is applied between phases. A phase generator that kept its count would restart out of step with the fetch.

// File: rtl/qseq_pkg.sv
`timescale 1ns/1ps
package qseq_pkg;
   localparam int NPHASE = 4;

   typedef enum logic [1:0] {
      PH_Q1 = 2'd0,
      PH_Q2 = 2'd1,
      PH_Q3 = 2'd2,
      PH_Q4 = 2'd3
   } phase_e;

   typedef logic [NPHASE-1:0] phase_oh_t;
endpackage

// File: rtl/qseq_phase_gen.sv
`timescale 1ns/1ps
module qseq_phase_gen
   import qseq_pkg::*;
#(
   parameter bit RING_ENC = 1'b1
) (
   input  logic      clk,
   input  logic      rst,
   output phase_oh_t ph_oh,
   output logic      div_clk
);
   generate
      if (RING_ENC) begin : g_ring
         phase_oh_t ring_q;
         always_ff @(posedge clk) begin
            if (rst) ring_q <= phase_oh_t'(1);
            else     ring_q <= {ring_q[NPHASE-2:0], ring_q[NPHASE-1]};
         end
         assign ph_oh = ring_q;
      end else begin : g_count
         phase_e cnt_q;
         always_ff @(posedge clk) begin
            if (rst) cnt_q <= PH_Q1;
            else     cnt_q <= phase_e'(cnt_q + 2'd1);
         end
         assign ph_oh = phase_oh_t'(1) << cnt_q;
      end
   endgenerate

   assign div_clk = ph_oh[PH_Q3] | ph_oh[PH_Q4];
endmodule

// File: rtl/qseq_redirect_latch.sv
`timescale 1ns/1ps
module qseq_redirect_latch #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              live,
   input  logic              cyc_end,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              take,
   output logic [ADDR_W-1:0] take_addr
);
   logic              pend_q;
   logic [ADDR_W-1:0] tgt_q;

   always_ff @(posedge clk) begin
      if (rst || cyc_end) begin
         pend_q <= 1'b0;
      end else if (live && req) begin
         pend_q <= 1'b1;
         tgt_q  <= req_addr;
      end
   end

   assign take      = live && (req || pend_q);
   assign take_addr = req ? req_addr : tgt_q;
endmodule

// File: rtl/qseq_fetch.sv
`timescale 1ns/1ps
module qseq_fetch #(
   parameter int                 ADDR_W   = 13,
   parameter int                 INSTR_W  = 14,
   parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cyc_end,
   input  logic               take,
   input  logic [ADDR_W-1:0]  take_addr,
   input  logic [INSTR_W-1:0] fetch_word,
   output logic [ADDR_W-1:0]  pc,
   output logic [INSTR_W-1:0] instr,
   output logic               bubble
);
   always_ff @(posedge clk) begin
      if (rst) begin
         pc     <= '0;
         instr  <= NOP_WORD;
         bubble <= 1'b1;
      end else if (cyc_end) begin
         if (take) begin
            pc     <= take_addr;
            instr  <= NOP_WORD;
            bubble <= 1'b1;
         end else begin
            pc     <= pc + 1'b1;
            instr  <= fetch_word;
            bubble <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/qphase_seq.sv
`timescale 1ns/1ps
module qphase_seq
   import qseq_pkg::*;
#(
   parameter int                 ADDR_W   = 13,
   parameter int                 INSTR_W  = 14,
   parameter logic [INSTR_W-1:0] NOP_WORD = '0,
   parameter bit                 RING_ENC = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   output logic [3:0]         q_phase,
   output logic               clk_out,
   output logic [ADDR_W-1:0]  pm_addr,
   input  logic [INSTR_W-1:0] pm_data,
   output logic [INSTR_W-1:0] ir,
   output logic               ex_bubble,
   input  logic               redirect_req,
   input  logic [ADDR_W-1:0]  redirect_addr,
   output logic               opr_rd_stb,
   output logic               dst_wr_stb
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("qphase_seq: ADDR_W out of range");
      end
      if (INSTR_W < 1) begin : g_bad_instr
         $error("qphase_seq: INSTR_W must be positive");
      end
   endgenerate

   phase_oh_t         ph;
   logic              take;
   logic [ADDR_W-1:0] take_addr;

   qseq_phase_gen #(.RING_ENC(RING_ENC)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .ph_oh   (ph),
      .div_clk (clk_out)
   );

   qseq_redirect_latch #(.ADDR_W(ADDR_W)) u_redir (
      .clk       (clk),
      .rst       (rst),
      .live      (!ex_bubble),
      .cyc_end   (ph[PH_Q4]),
      .req       (redirect_req),
      .req_addr  (redirect_addr),
      .take      (take),
      .take_addr (take_addr)
   );

   qseq_fetch #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .NOP_WORD(NOP_WORD)) u_fetch (
      .clk        (clk),
      .rst        (rst),
      .cyc_end    (ph[PH_Q4]),
      .take       (take),
      .take_addr  (take_addr),
      .fetch_word (pm_data),
      .pc         (pm_addr),
      .instr      (ir),
      .bubble     (ex_bubble)
   );

   assign q_phase    = ph;
   assign opr_rd_stb = ph[PH_Q2] & ~ex_bubble;
   assign dst_wr_stb = ph[PH_Q4] & ~ex_bubble;
endmodule

// File: rtl/qseq_chk.sv
`timescale 1ns/1ps
module qseq_chk #(
   parameter int                 ADDR_W   = 13,
   parameter int                 INSTR_W  = 14,
   parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
   input logic               clk,
   input logic               rst,
   input logic [3:0]         q_phase,
   input logic               clk_out,
   input logic [ADDR_W-1:0]  pm_addr,
   input logic [INSTR_W-1:0] ir,
   input logic               ex_bubble,
   input logic               redirect_req,
   input logic               opr_rd_stb,
   input logic               dst_wr_stb
);
   AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(q_phase) == 1); // R1
   AST_PHASE_ROTATE: assert property (@(posedge clk) disable iff (rst)
      q_phase == 4'b1000 |=> q_phase == 4'b0001); // R1
   AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
      !q_phase[3] |=> $stable(pm_addr)); // R3
   AST_RD_SLOT: assert property (@(posedge clk) disable iff (rst)
      opr_rd_stb |-> (q_phase[1] && !ex_bubble)); // R5
   AST_WR_SLOT: assert property (@(posedge clk) disable iff (rst)
      dst_wr_stb |-> (q_phase[3] && !ex_bubble)); // R5
   AST_CLKOUT_HALF: assert property (@(posedge clk) disable iff (rst)
      q_phase[0] |-> !clk_out); // R6
   AST_JUMP_FLUSH: assert property (@(posedge clk) disable iff (rst)
      (q_phase[3] && redirect_req && !ex_bubble) |=> (ir == NOP_WORD && ex_bubble)); // R7
   AST_BUBBLE_ONCE: assert property (@(posedge clk) disable iff (rst)
      (q_phase[3] && ex_bubble) |=> !ex_bubble); // R8
endmodule

bind qphase_seq qseq_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .NOP_WORD(NOP_WORD)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .q_phase      (q_phase),
   .clk_out      (clk_out),
   .pm_addr      (pm_addr),
   .ir           (ir),
   .ex_bubble    (ex_bubble),
   .redirect_req (redirect_req),
   .opr_rd_stb   (opr_rd_stb),
   .dst_wr_stb   (dst_wr_stb)
);

// File: tb/tb_qphase_seq.sv
`timescale 1ns/1ps
module tb_qphase_seq;
   localparam int AW = 4;
   localparam int IW = 8;
   localparam logic [IW-1:0] NOPW = 8'h00;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [3:0]    q_phase;
   logic          clk_out;
   logic [AW-1:0] pm_addr;
   logic [IW-1:0] pm_data;
   logic [IW-1:0] ir;
   logic          ex_bubble;
   logic          redirect_req = 1'b0;
   logic [AW-1:0] redirect_addr = '0;
   logic          opr_rd_stb, dst_wr_stb;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int            m_pc;
   logic [IW-1:0] m_ir;
   bit            m_bub;

   always #2.5 clk = ~clk;

   function automatic logic [IW-1:0] memw(input int a);
      return 8'(((a * 29 + 7) & 8'h7F) | 8'h80);
   endfunction

   assign pm_data = memw(int'(pm_addr));

   qphase_seq #(.ADDR_W(AW), .INSTR_W(IW), .NOP_WORD(NOPW)) dut (
      .clk(clk), .rst(rst), .q_phase(q_phase), .clk_out(clk_out),
      .pm_addr(pm_addr), .pm_data(pm_data), .ir(ir), .ex_bubble(ex_bubble),
      .redirect_req(redirect_req), .redirect_addr(redirect_addr),
      .opr_rd_stb(opr_rd_stb), .dst_wr_stb(dst_wr_stb)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pc = 0; m_ir = NOPW; m_bub = 1'b1;
   endtask

   // drive reset at negedges; returns at the negedge that shows phase Q1
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; redirect_req = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_reset();
      #1;
      chk(q_phase == 4'b0001, "R2 phase", int'(q_phase), 1);
      chk(pm_addr == '0, "R2 addr", int'(pm_addr), 0);
      chk(ir == NOPW, "R2 ir", int'(ir), int'(NOPW));
      chk(ex_bubble == 1'b1, "R2 bubble", int'(ex_bubble), 1);
   endtask

   // mode 0: no request; 1: single pulse in phase c%4; 2: pulses in Q1 and Q3
   task automatic run_cycle(input int c, input int mode, input int nph);
      bit      taken = 1'b0;
      int      tgt = 0;
      for (int p = 0; p < nph; p++) begin
         redirect_req = 1'b0;
         if (mode == 1 && p == (c % 4)) begin
            redirect_req = 1'b1; redirect_addr = AW'((c * 7 + 3) % 16);
         end
         if (mode == 2 && (p == 0 || p == 2)) begin
            redirect_req = 1'b1;
            redirect_addr = (p == 0) ? AW'((c * 5 + 1) % 16) : AW'((c * 3 + 11) % 16);
         end
         if (redirect_req && !m_bub) begin
            taken = 1'b1; tgt = int'(redirect_addr);   // last pulse wins (R9)
         end
         #1;
         chk(q_phase == 4'(1 << p), "R1 phase", int'(q_phase), 1 << p);
         chk(clk_out == (p >= 2), "R6 clk_out", int'(clk_out), int'(p >= 2));
         chk(opr_rd_stb == (p == 1 && !m_bub), "R5 rd", int'(opr_rd_stb), int'(p == 1 && !m_bub));
         chk(dst_wr_stb == (p == 3 && !m_bub), "R5 wr", int'(dst_wr_stb), int'(p == 3 && !m_bub));
         chk(int'(pm_addr) == m_pc, "R3 R4 R7 R8 R9 addr", int'(pm_addr), m_pc);
         chk(ir == m_ir, "R4 R7 ir", int'(ir), int'(m_ir));
         chk(ex_bubble == m_bub, "R7 R8 bubble", int'(ex_bubble), int'(m_bub));
         @(negedge clk);
      end
      redirect_req = 1'b0;
      if (nph == 4) begin
         if (taken) begin
            m_pc = tgt; m_ir = NOPW; m_bub = 1'b1;
         end else begin
            m_ir = memw(m_pc); m_pc = (m_pc + 1) % 16; m_bub = 1'b0;
         end
      end
   endtask

   initial begin
      model_reset();
      do_reset();
      // long sequential run: wrap-around of the fetch address (R4)
      for (int c = 0; c < 40; c++) run_cycle(c, 0, 4);
      // jumps in every phase, in bubble cycles, and double pulses (R7 R8 R9)
      for (int c = 0; c < 200; c++) begin
         int k = c % 5;
         run_cycle(c, (k == 0) ? 0 : ((k == 3 || k == 4) ? 2 : 1), 4);
      end
      // reset in mid-cycle (R2)
      run_cycle(0, 0, 2);
      do_reset();
      for (int c = 0; c < 30; c++) run_cycle(c, (c % 3 == 1) ? 1 : 0, 4);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule